// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block sits between a 16-bit parallel video source and a capture port that only understands separate sync wires. Each pixel clock carries one 8-bit luma sample and one 8-bit chroma sample (Cb and Cr alternating) in two lanes. Line and frame timing is present only as embedded timing codes in the stream. The block searches the luma lane for these codes and turns them into horizontal sync, vertical sync, an explicit field flag and a data-valid strobe. All of these are aligned cycle for cycle with a delayed copy of the pixel data.

Because the field flag is decoded from every code, a downstream deinterlacer always knows which field a line belongs to and cannot swap the two fields of an interlaced frame. A bypass input forwards the raw stream, codes included, and holds every timing output low. Decoding carries on internally while bypass is set.

Top module: `av_sync_decoder`

## Requirements
- R1: A timing code is four consecutive words whose luma lane reads all-ones (0xFF), 0x00, 0x00, XY. The luma lane is the upper byte `dataIn[15:8]` when LUMA_HIGH=1. The chroma lane plays no part in detection. XY bit 6 is the field flag F, bit 5 is the blanking flag V, and bit 4 is H, where 1 marks end of active video (EAV) and 0 marks start of active video (SAV).
- R2: An XY word is accepted only if bit 7 is 1 and bits [3:0] equal {V^H, F^H, F^V, F^V^H}. A code that fails this check does not change any timing output, and its words pass through as ordinary data.
- R3: `codeErr` goes high after a code fails the R2 check and stays high until reset.
- R4: `hSync` is high on the output words that follow the XY word of an accepted EAV. It stays high up to and including the XY word of the next accepted SAV.
- R5: `vSync` equals the V bit of the most recently accepted code and applies to the words that follow that code's XY word.
- R6: `field` equals the F bit of the most recently accepted code and applies to the words that follow that code's XY word.
- R7: `dataValid` is high only on words that follow an accepted SAV with V=0 and come before the next accepted code. The four words of an accepted code are never valid, and `dataValid` implies `hSync` and `vSync` are low.
- R8: `dataOut` equals the `dataIn` word sampled five rising edges earlier, and every timing output refers to that same word.
- R9: While `bypass` is high at the output register's edge, `hSync`, `vSync`, `field` and `dataValid` are low and `dataOut` still carries the unchanged delayed stream.
- R10: A synchronous active-high `rst` clears all outputs, the error flag and the field state to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Forward raw stream, timing outputs held low |
| dataIn | input | 2*LANE_W | Luma and chroma lanes of one pixel clock |
| dataOut | output | 2*LANE_W | Input stream delayed to match the timing outputs |
| dataValid | output | 1 | Output word is an active pixel |
| hSync | output | 1 | Horizontal blanking, active high |
| vSync | output | 1 | Vertical blanking, active high |
| field | output | 1 | Field of the current line (0 or 1) |
| codeErr | output | 1 | Sticky flag for a timing code with bad protection |

## Verification
The bench uses the defaults LANE_W=8 and LUMA_HIGH=1, so codes sit in the upper byte and the chroma lane carries a fixed 0x80 during codes. Under these values the bench can run full blanking lines and active lines in both fields, a code with corrupted protection bits inside a blanking interval, and a switch into and out of bypass in the middle of a line. Each output word is predicted from the requirements and compared, field by field, at the cycle it emerges.

// File: rtl/av_sync_pkg.sv
package av_sync_pkg;

  localparam int CODE_LEN = 4;

  // timing attributes carried alongside every word in the pipeline
  typedef struct packed {
    logic valid;
    logic hs;
    logic vs;
    logic fld;
  } tag_t;

  // result of inspecting the four newest words
  typedef struct packed {
    logic hit;   // well-formed code found
    logic bad;   // preamble found, protection wrong
    logic f;
    logic v;
    logic h;
  } code_t;

  // control to datapath strobes
  typedef struct packed {
    logic kill;  // strip valid from words currently in the pipeline
    tag_t next;  // attributes for the word entering the pipeline
  } strobe_t;

  function automatic logic [3:0] protBits(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/av_code_datapath.sv
module av_code_datapath
  import av_sync_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter bit LUMA_HIGH = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bypass,
  input  logic [2*LANE_W-1:0] dataIn,
  input  strobe_t             strobe,
  output code_t               code,
  output logic [2*LANE_W-1:0] dataOut,
  output logic                dataValid,
  output logic                hSync,
  output logic                vSync,
  output logic                field
);

  localparam int W = 2 * LANE_W;

  logic [W-1:0]      dataPipe [CODE_LEN];
  tag_t              tagPipe  [CODE_LEN];
  logic [LANE_W-1:0] lumaPipe [CODE_LEN];
  tag_t              outTag;
  logic [7:0]        xy;
  logic              preamble;
  logic              xyOk;

  // pick the lane that carries the codes
  for (genvar g = 0; g < CODE_LEN; g++) begin : g_lane
    if (LUMA_HIGH) begin : g_hi
      assign lumaPipe[g] = dataPipe[g][W-1 -: LANE_W];
    end else begin : g_lo
      assign lumaPipe[g] = dataPipe[g][LANE_W-1:0];
    end
  end

  // oldest word first: all-ones, zero, zero, then the XY word
  assign preamble = (lumaPipe[CODE_LEN-1] == {LANE_W{1'b1}}) &&
                    (lumaPipe[CODE_LEN-2] == '0) &&
                    (lumaPipe[CODE_LEN-3] == '0);
  assign xy   = lumaPipe[0][LANE_W-1 -: 8];
  assign xyOk = xy[7] && (xy[3:0] == protBits(xy[6], xy[5], xy[4]));

  always_comb begin
    code.hit = preamble && xyOk;
    code.bad = preamble && !xyOk;
    code.f   = xy[6];
    code.v   = xy[5];
    code.h   = xy[4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CODE_LEN; i++) begin
        dataPipe[i] <= '0;
        tagPipe[i]  <= '0;
      end
      dataOut <= '0;
      outTag  <= '0;
    end else begin
      dataPipe[0] <= dataIn;
      tagPipe[0]  <= strobe.next;
      for (int i = 1; i < CODE_LEN; i++) begin
        dataPipe[i]       <= dataPipe[i-1];
        tagPipe[i]        <= tagPipe[i-1];
        tagPipe[i].valid  <= tagPipe[i-1].valid && !strobe.kill;
      end
      dataOut <= dataPipe[CODE_LEN-1];
      if (bypass) begin
        outTag <= '0;
      end else begin
        outTag       <= tagPipe[CODE_LEN-1];
        outTag.valid <= tagPipe[CODE_LEN-1].valid && !strobe.kill;
      end
    end
  end

  assign dataValid = outTag.valid;
  assign hSync     = outTag.hs;
  assign vSync     = outTag.vs;
  assign field     = outTag.fld;

  AST_CODE_WORDS_INVALID: assert property (@(posedge clk) disable iff (rst)
    strobe.kill |=> !tagPipe[1].valid && !tagPipe[2].valid && !tagPipe[3].valid && !dataValid); // R7

  AST_VALID_OUTSIDE_BLANK: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> !hSync && !vSync); // R7

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(bypass) |-> !dataValid && !hSync && !vSync && !field); // R9

  AST_DATA_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dataOut == $past(dataPipe[CODE_LEN-1])); // R8

endmodule

// File: rtl/av_timing_ctrl.sv
module av_timing_ctrl
  import av_sync_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  code_t   code,
  output strobe_t strobe,
  output logic    codeErr
);

  tag_t cur;
  tag_t nextState;

  always_comb begin
    nextState = cur;
    if (code.hit) begin
      nextState.valid = !code.h && !code.v;
      nextState.hs    = code.h;
      nextState.vs    = code.v;
      nextState.fld   = code.f;
    end
    strobe.kill = code.hit;
    strobe.next = nextState;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= '0;
      codeErr <= 1'b0;
    end else begin
      cur     <= nextState;
      codeErr <= codeErr || code.bad;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    codeErr |=> codeErr); // R3

  AST_BAD_RAISES_ERR: assert property (@(posedge clk) disable iff (rst)
    code.bad |=> codeErr); // R2

  AST_BAD_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    !code.hit |=> $stable(cur)); // R2

  AST_HIT_LOADS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    code.hit |=> cur.fld == $past(code.f) && cur.vs == $past(code.v) && cur.hs == $past(code.h)); // R6

endmodule

// File: rtl/av_sync_decoder.sv
module av_sync_decoder
  import av_sync_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter bit LUMA_HIGH = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bypass,
  input  logic [2*LANE_W-1:0] dataIn,
  output logic [2*LANE_W-1:0] dataOut,
  output logic                dataValid,
  output logic                hSync,
  output logic                vSync,
  output logic                field,
  output logic                codeErr
);

  code_t   code;
  strobe_t strobe;

  av_code_datapath #(
    .LANE_W   (LANE_W),
    .LUMA_HIGH(LUMA_HIGH)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .bypass   (bypass),
    .dataIn   (dataIn),
    .strobe   (strobe),
    .code     (code),
    .dataOut  (dataOut),
    .dataValid(dataValid),
    .hSync    (hSync),
    .vSync    (vSync),
    .field    (field)
  );

  av_timing_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .code   (code),
    .strobe (strobe),
    .codeErr(codeErr)
  );

endmodule

// File: tb/test_av_sync_decoder.sv
`timescale 1ns/100ps
module test_av_sync_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bypass = 1'b0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataValid, hSync, vSync, field, codeErr;

  av_sync_decoder i_av_sync_decoder (
    .clk(clk), .rst(rst), .bypass(bypass), .dataIn(dataIn),
    .dataOut(dataOut), .dataValid(dataValid), .hSync(hSync),
    .vSync(vSync), .field(field), .codeErr(codeErr)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          due;
    logic [15:0] data;
    logic        valid;
    logic        hs;
    logic        vs;
    logic        fld;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errs = 0;
  bit   done = 0;

  // model state from the requirements
  logic mActive = 0, mHs = 0, mVs = 0, mFld = 0;
  logic nextByp = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic pushWord(input logic [7:0] y, input logic [7:0] c, input logic valid);
    exp_t e;
    @(negedge clk);
    bypass = nextByp;
    dataIn = {y, c};
    e.due = cyc + 5; e.data = {y, c}; e.valid = valid;
    e.hs = mHs; e.vs = mVs; e.fld = mFld;
    q.push_back(e);
  endtask

  task automatic pixel(input logic [7:0] y, input logic [7:0] c);
    pushWord(y, c, mActive);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) pixel(8'h10, 8'h80);
  endtask

  task automatic code(input logic f, input logic v, input logic h, input bit corrupt);
    logic [7:0] xy;
    logic       vflag;
    xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    if (corrupt) xy = xy ^ 8'h05;
    vflag = corrupt ? mActive : 1'b0;
    pushWord(8'hFF, 8'h80, vflag);
    pushWord(8'h00, 8'h80, vflag);
    pushWord(8'h00, 8'h80, vflag);
    pushWord(xy,    8'h80, vflag);
    if (!corrupt) begin
      mActive = !h && !v; mHs = h; mVs = v; mFld = f;
    end
  endtask

  task automatic line(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      pixel(seed + 8'(i * 7), (i % 2 == 0) ? 8'h40 + 8'(i) : 8'hC0 - 8'(i));
  endtask

  // monitor: compare each word when it reaches the outputs
  always @(posedge clk) begin
    logic bypS;
    exp_t e;
    bypS = bypass;
    cyc++;
    #1;
    while (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      chk("R8 dataOut", dataOut, e.data);
      if (bypS) begin
        chk("R9 dataValid", dataValid, 0);
        chk("R9 hSync", hSync, 0);
        chk("R9 vSync", vSync, 0);
        chk("R9 field", field, 0);
      end else begin
        chk("R7 dataValid", dataValid, e.valid);
        chk("R4 hSync", hSync, e.hs);
        chk("R5 vSync", vSync, e.vs);
        chk("R6 field", field, e.fld);
      end
    end
  end

  task automatic drain;
    idle(8);
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    dataIn = 16'hFF00;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 dataValid", dataValid, 0);
    chk("R10 hSync", hSync, 0);
    chk("R10 vSync", vSync, 0);
    chk("R10 field", field, 0);
    chk("R10 codeErr", codeErr, 0);
    chk("R10 dataOut", dataOut, 0);
    rst = 1'b0;

    idle(6);
    // R1/R5 vertical blanking line, field 0
    code(0, 1, 1, 0); idle(6);
    code(0, 1, 0, 0); idle(8);
    // R4/R7 active lines, field 0
    code(0, 0, 1, 0); idle(4);
    code(0, 0, 0, 0); line(12, 8'h20);
    code(0, 0, 1, 0); idle(4);
    code(0, 0, 0, 0); line(6, 8'h31);
    // R6 second field
    code(1, 1, 1, 0); idle(5);
    code(1, 1, 0, 0); idle(3);
    code(1, 0, 1, 0); idle(4);
    code(1, 0, 0, 0); line(8, 8'h55);
    code(1, 0, 1, 0); idle(4);
    chk("R3 codeErr before bad code", codeErr, 0);
    // R2 corrupted SAV: ignored, blanking continues
    code(1, 0, 0, 1); line(4, 8'h66);
    chk("R3 codeErr after bad code", codeErr, 1);
    code(1, 0, 0, 0); line(5, 8'h70);
    chk("R3 codeErr stays set", codeErr, 1);
    code(1, 0, 1, 0); idle(3);
    // R9 bypass across a line
    nextByp = 1;
    code(0, 0, 0, 0); line(6, 8'h81);
    code(0, 0, 1, 0); idle(2);
    nextByp = 0;
    idle(4);
    code(0, 0, 0, 0); line(5, 8'h92);
    code(0, 0, 1, 0);
    drain();

    // R10 reset clears sticky flag
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 codeErr cleared", codeErr, 0);
    chk("R10 hSync after reset", hSync, 0);
    chk("R10 field after reset", field, 0);
    chk("R10 dataValid after reset", dataValid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule